// File: doc/BRIEF.md
# Masked Vector Register Move Unit

This block computes the next value of a 512-bit vector destination for a packed move of 64-bit elements. It takes a source vector, the current destination contents, a per-element write mask and a handful of control selects: the encoding class, the vector length, merge or zero masking, and register/load form versus store form. From these it decides, for every 64-bit element, whether the element takes the source value, keeps its old value or is cleared.

The same decision covers the bits above the selected vector length. They are cleared, kept or left alone depending on the encoding class and on whether the move writes a register or memory. The block also validates a 4-bit reserved specifier and rejects illegal combinations of encoding class and length. A rejected move raises a fault flag and passes the old destination through unchanged.

Results are registered. They appear one clock after a valid strobe, together with an output-valid pulse.

Top module: `vec_mask_move`

## Requirements
- R1: `vlen_sel` 0 selects 128 bits (2 elements), 1 selects 256 bits (4 elements) and 2 selects 512 bits (8 elements). Element j occupies bits 64j+63 down to 64j of every vector port.
- R2: An active element j takes the source element when masking is off or when `mask_bits[j]` is 1.
- R3: In register/load form (`store_form`=0) with EVEX encoding and masking on, an element whose mask bit is 0 keeps its old destination value when `zero_mode`=0 and becomes zero when `zero_mode`=1.
- R4: In store form (`store_form`=1), an element whose mask bit is 0 always keeps its old value, whatever `zero_mode` is.
- R5: In register/load form with VEX (`enc_sel`=1) or EVEX (`enc_sel`=2) encoding, every bit above the selected vector length becomes zero.
- R6: In register/load form with legacy encoding (`enc_sel`=0), bits 511 down to 128 keep their old destination value.
- R7: In store form, every bit above the selected vector length keeps its old destination value.
- R8: With VEX or EVEX encoding, a `spec_field` other than 4'b1111 sets `out_fault`, and `out_vec` equals the old destination.
- R9: Mask bits at positions equal to or above the active element count have no effect on the result.
- R10: With legacy or VEX encoding, `mask_on` and `zero_mode` have no effect: every active element takes the source.
- R11: `enc_sel`=3, `vlen_sel`=3, legacy encoding with a length other than 128, and VEX encoding with 512 bits all set `out_fault` and leave the destination unchanged.
- R12: The outputs update on the clock edge after `in_valid`=1, and `out_valid` pulses in that same cycle. When `in_valid`=0, `out_valid` is 0 and `out_vec` and `out_fault` hold. A synchronous active-high `rst` clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Move request strobe |
| src_vec | input | 512 | Source vector |
| dst_vec | input | 512 | Current destination value |
| mask_bits | input | 8 | Per-element write mask |
| mask_on | input | 1 | Masking enabled |
| zero_mode | input | 1 | 1 = zeroing masking, 0 = merging masking |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2=512 |
| enc_sel | input | 2 | Encoding class: 0=legacy, 1=VEX, 2=EVEX |
| store_form | input | 1 | 1 = store form, 0 = register/load form |
| spec_field | input | 4 | Reserved specifier, must be 4'b1111 for VEX/EVEX |
| out_valid | output | 1 | Result valid pulse |
| out_vec | output | 512 | Next destination value |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
Two decisions can fall in the same cycle: the per-element mask decision inside the vector length, and the clear-or-keep decision above it. A reserved-field fault can also override both at once. The bench provokes this with EVEX 128- and 256-bit moves whose mask bits are set both inside and above the element count, with zero mode on, in register and store form, and with bad specifiers. A behavioural model judges every cycle's full 512-bit result, which checks both regions and the fault override together.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_VEX    = 2'd1,
        ENC_EVEX   = 2'd2,
        ENC_BAD    = 2'd3
    } enc_e;

    typedef enum logic [1:0] {
        LEN_128 = 2'd0,
        LEN_256 = 2'd1,
        LEN_512 = 2'd2,
        LEN_BAD = 2'd3
    } len_e;
endpackage

// File: rtl/vmm_legality.sv
module vmm_legality
    import vmm_pkg::*;
#(
    parameter int SPEC_W = 4
) (
    input  enc_e              enc,
    input  len_e              vlen,
    input  logic [SPEC_W-1:0] spec,
    output logic              fault
);
    localparam logic [SPEC_W-1:0] SPEC_OK = {SPEC_W{1'b1}};

    logic spec_bad;
    logic combo_bad;

    always_comb begin
        spec_bad  = (enc == ENC_VEX || enc == ENC_EVEX) && (spec != SPEC_OK);
        combo_bad = (enc == ENC_BAD) || (vlen == LEN_BAD)
                 || (enc == ENC_LEGACY && vlen != LEN_128)
                 || (enc == ENC_VEX && vlen == LEN_512);
        fault     = spec_bad || combo_bad;
    end
endmodule

// File: rtl/vmm_lane_ctrl.sv
module vmm_lane_ctrl
    import vmm_pkg::*;
#(
    parameter int NUM_ELEM = 8
) (
    input  enc_e                enc,
    input  len_e                vlen,
    input  logic                store,
    input  logic                mask_on,
    input  logic                zero_mode,
    input  logic [NUM_ELEM-1:0] mask,
    output logic [NUM_ELEM-1:0] take_src,
    output logic [NUM_ELEM-1:0] clear
);
    localparam int CNT_W = $clog2(NUM_ELEM) + 1;

    logic [CNT_W-1:0] elem_cnt;
    logic             mask_act;
    logic             zero_act;
    logic             upper_clear;

    always_comb begin
        elem_cnt    = CNT_W'(2) << vlen;
        mask_act    = mask_on && (enc == ENC_EVEX);
        zero_act    = zero_mode && (enc == ENC_EVEX) && !store;
        upper_clear = !store && (enc != ENC_LEGACY);
    end

    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_lane
        logic active;
        always_comb begin
            active      = CNT_W'(j) < elem_cnt;
            take_src[j] = active && (!mask_act || mask[j]);
            clear[j]    = active ? (!take_src[j] && zero_act) : upper_clear;
        end
    end
endmodule

// File: rtl/vmm_lane_mux.sv
module vmm_lane_mux #(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8
) (
    input  logic [NUM_ELEM*ELEM_W-1:0] src,
    input  logic [NUM_ELEM*ELEM_W-1:0] dst,
    input  logic [NUM_ELEM-1:0]        take_src,
    input  logic [NUM_ELEM-1:0]        clear,
    output logic [NUM_ELEM*ELEM_W-1:0] result
);
    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_elem
        always_comb begin
            if (take_src[j])
                result[j*ELEM_W +: ELEM_W] = src[j*ELEM_W +: ELEM_W];
            else if (clear[j])
                result[j*ELEM_W +: ELEM_W] = '0;
            else
                result[j*ELEM_W +: ELEM_W] = dst[j*ELEM_W +: ELEM_W];
        end
    end
endmodule

// File: rtl/vec_mask_move.sv
module vec_mask_move
    import vmm_pkg::*;
#(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8,
    parameter int SPEC_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [NUM_ELEM*ELEM_W-1:0] src_vec,
    input  logic [NUM_ELEM*ELEM_W-1:0] dst_vec,
    input  logic [NUM_ELEM-1:0]        mask_bits,
    input  logic                       mask_on,
    input  logic                       zero_mode,
    input  logic [1:0]                 vlen_sel,
    input  logic [1:0]                 enc_sel,
    input  logic                       store_form,
    input  logic [SPEC_W-1:0]          spec_field,
    output logic                       out_valid,
    output logic [NUM_ELEM*ELEM_W-1:0] out_vec,
    output logic                       out_fault
);
    localparam int VEC_W = NUM_ELEM * ELEM_W;
    localparam int LO_W  = 2 * ELEM_W;

    typedef struct packed {
        logic             valid;
        logic             fault;
        logic [VEC_W-1:0] vec;
    } state_t;

    enc_e                enc;
    len_e                vlen;
    logic                fault_d;
    logic [NUM_ELEM-1:0] take_src;
    logic [NUM_ELEM-1:0] clear;
    logic [VEC_W-1:0]    lane_out;
    state_t              nxt_d;
    state_t              cur_q;

    assign enc  = enc_e'(enc_sel);
    assign vlen = len_e'(vlen_sel);

    vmm_legality #(.SPEC_W(SPEC_W)) u_legal (
        .enc   (enc),
        .vlen  (vlen),
        .spec  (spec_field),
        .fault (fault_d)
    );

    vmm_lane_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
        .enc       (enc),
        .vlen      (vlen),
        .store     (store_form),
        .mask_on   (mask_on),
        .zero_mode (zero_mode),
        .mask      (mask_bits),
        .take_src  (take_src),
        .clear     (clear)
    );

    vmm_lane_mux #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_mux (
        .src      (src_vec),
        .dst      (dst_vec),
        .take_src (take_src),
        .clear    (clear),
        .result   (lane_out)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        if (in_valid) begin
            nxt_d.valid = 1'b1;
            nxt_d.fault = fault_d;
            nxt_d.vec   = fault_d ? dst_vec : lane_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign out_valid = cur_q.valid;
    assign out_fault = cur_q.fault;
    assign out_vec   = cur_q.vec;

    // Output timing
    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // Faulting move passes the destination through
    assert_fault_keeps_dst_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && enc != ENC_LEGACY && spec_field != {SPEC_W{1'b1}}
        |=> out_fault && out_vec == $past(dst_vec));

    // Upper bits cleared for EVEX register/load at 128 bits
    assert_evex_upper_clear_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && !fault_d && enc == ENC_EVEX && !store_form && vlen == LEN_128
        |=> out_vec[VEC_W-1:LO_W] == '0);

    // Legacy register/load keeps upper bits
    assert_legacy_upper_keep_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && !fault_d && enc == ENC_LEGACY && !store_form
        |=> out_vec[VEC_W-1:LO_W] == $past(dst_vec[VEC_W-1:LO_W]));

    // Store form keeps upper bits at 128 bits
    assert_store_upper_keep_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && !fault_d && store_form && vlen == LEN_128
        |=> out_vec[VEC_W-1:LO_W] == $past(dst_vec[VEC_W-1:LO_W]));

    // VEX ignores mask controls
    assert_vex_copies_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && !fault_d && enc == ENC_VEX
        |=> out_vec[LO_W-1:0] == $past(src_vec[LO_W-1:0]));
endmodule

// File: tb/vec_mask_move_tb.sv
module vec_mask_move_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [511:0] src_vec, dst_vec;
    logic [7:0]   mask_bits;
    logic         mask_on, zero_mode, store_form;
    logic [1:0]   vlen_sel, enc_sel;
    logic [3:0]   spec_field;
    logic         out_valid, out_fault;
    logic [511:0] out_vec;

    int n_run  = 0;
    int n_fail = 0;

    logic [511:0] exp_vec;
    logic         exp_fault, exp_valid;

    always #5 clk = ~clk;

    vec_mask_move u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .dst_vec(dst_vec), .mask_bits(mask_bits), .mask_on(mask_on),
        .zero_mode(zero_mode), .vlen_sel(vlen_sel), .enc_sel(enc_sel),
        .store_form(store_form), .spec_field(spec_field),
        .out_valid(out_valid), .out_vec(out_vec), .out_fault(out_fault)
    );

    function automatic logic [511:0] rand_vec();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Behavioural reference model
    task automatic model(output logic [511:0] r, output logic f);
        int  cnt;
        bit  masking, zeroing, en;
        cnt = 2 << vlen_sel;
        f = (enc_sel == 3) || (vlen_sel == 3) ||
            (enc_sel == 0 && vlen_sel != 0) || (enc_sel == 1 && vlen_sel == 2) ||
            (enc_sel != 0 && spec_field != 4'hF);
        masking = mask_on && enc_sel == 2;
        zeroing = zero_mode && enc_sel == 2;
        r = dst_vec;
        if (!f) begin
            for (int j = 0; j < 8; j++) begin
                if (j >= cnt) begin
                    if (!store_form && enc_sel != 0) r[j*64 +: 64] = '0;
                end else begin
                    en = !masking || mask_bits[j];
                    if (en)                           r[j*64 +: 64] = src_vec[j*64 +: 64];
                    else if (!store_form && zeroing)  r[j*64 +: 64] = '0;
                end
            end
        end
    endtask

    task automatic check(input string tag);
        n_run++;
        if (out_valid !== exp_valid || out_fault !== exp_fault || out_vec !== exp_vec) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b f=%0b vec=%h expected v=%0b f=%0b vec=%h",
                     tag, out_valid, out_fault, out_vec, exp_valid, exp_fault, exp_vec);
        end
    endtask

    // At a negedge: drive, predict, wait one cycle, compare at the next negedge
    task automatic apply(input string tag, input logic v, input logic [1:0] enc,
                         input logic [1:0] vl, input logic st, input logic mon,
                         input logic zm, input logic [7:0] mk, input logic [3:0] sp);
        logic [511:0] r;
        logic f;
        in_valid = v; enc_sel = enc; vlen_sel = vl; store_form = st;
        mask_on = mon; zero_mode = zm; mask_bits = mk; spec_field = sp;
        src_vec = rand_vec(); dst_vec = rand_vec();
        model(r, f);
        if (v) begin exp_valid = 1'b1; exp_vec = r; exp_fault = f; end
        else   exp_valid = 1'b0;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; src_vec = '1; dst_vec = '1; mask_bits = '0;
        mask_on = 1'b0; zero_mode = 1'b0; store_form = 1'b0;
        vlen_sel = '0; enc_sel = '0; spec_field = '0;
        exp_vec = '0; exp_fault = 1'b0; exp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 reset");
        rst = 1'b0;

        apply("R1 R2 evex 512 unmasked",       1, 2, 2, 0, 0, 0, 8'h00, 4'hF);
        apply("R1 evex 256 unmasked",          1, 2, 1, 0, 0, 0, 8'h00, 4'hF);
        apply("R3 evex merge",                 1, 2, 2, 0, 1, 0, 8'hA5, 4'hF);
        apply("R3 evex zero",                  1, 2, 2, 0, 1, 1, 8'h5A, 4'hF);
        apply("R4 store zero ignored",         1, 2, 2, 1, 1, 1, 8'h3C, 4'hF);
        apply("R5 evex 128 upper clear",       1, 2, 0, 0, 1, 1, 8'hFD, 4'hF);
        apply("R5 vex 256 upper clear",        1, 1, 1, 0, 0, 0, 8'h00, 4'hF);
        apply("R5 vex 128 upper clear",        1, 1, 0, 0, 0, 0, 8'h00, 4'hF);
        apply("R6 legacy upper keep",          1, 0, 0, 0, 0, 0, 8'h00, 4'h0);
        apply("R7 store evex 128 upper keep",  1, 2, 0, 1, 1, 0, 8'hFE, 4'hF);
        apply("R7 store vex 256 upper keep",   1, 1, 1, 1, 0, 0, 8'h00, 4'hF);
        apply("R8 vex bad spec",               1, 1, 0, 0, 0, 0, 8'h00, 4'hE);
        apply("R8 evex bad spec",              1, 2, 2, 0, 1, 1, 8'h0F, 4'h7);
        apply("R9 upper mask bits ignored",    1, 2, 1, 0, 1, 1, 8'hF0, 4'hF);
        apply("R9 upper mask bits ignored st", 1, 2, 0, 1, 1, 0, 8'hFC, 4'hF);
        apply("R10 vex mask ignored",          1, 1, 1, 0, 1, 1, 8'h00, 4'hF);
        apply("R10 legacy mask ignored",       1, 0, 0, 0, 1, 1, 8'h00, 4'h3);
        apply("R11 enc 3",                     1, 3, 0, 0, 0, 0, 8'h00, 4'hF);
        apply("R11 vlen 3",                    1, 2, 3, 0, 0, 0, 8'hFF, 4'hF);
        apply("R11 legacy 256",                1, 0, 1, 0, 0, 0, 8'h00, 4'hF);
        apply("R11 vex 512",                   1, 1, 2, 0, 0, 0, 8'h00, 4'hF);
        apply("R12 idle holds",                0, 2, 2, 0, 0, 0, 8'h00, 4'hF);
        apply("R12 idle holds again",          0, 1, 0, 1, 1, 1, 8'hFF, 4'h0);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] e, l;
            logic       s, bad;
            string      tag;
            e   = 2'($urandom_range(0, 2));
            l   = 2'($urandom_range(0, 2));
            s   = 1'($urandom);
            bad = ($urandom_range(0, 7) == 0);
            if (e == 0) l = 0;
            if (e == 1 && l == 2) l = 1;
            tag = bad ? "R8 random" : s ? "R7 random" : (e == 0) ? "R6 random" : "R5 random";
            apply(tag, 1'($urandom_range(0, 5) != 0), e, l, s, 1'($urandom), 1'($urandom),
                  8'($urandom), bad ? 4'h6 : 4'hF);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule